// File: doc/BRIEF.md
# ASCII Command Bus Master Bridge

This block lets an external host reach every register and memory location of the device over a serial console, without help from the processor. Received characters arrive one byte at a time from a UART receiver over a valid/ready interface. The block parses a small text command language: "wm" to write and "rm" to read, each followed by hexadecimal operands. It then runs one transaction as the single master of a Wishbone-style bus with 32-bit address and data. The result goes back as text, one byte at a time, to a UART transmitter over a second valid/ready interface.

A write line reads `wm <address> <data>` and a read line reads `rm <address>`. Every operand is exactly eight hex digits, and one or more spaces separate the operands from each other and from the command word. A line ends with CR or LF. A write is answered with "OK", a read with the eight digits of the word that was read, and any malformed input or bus timeout with "ERR". Every answer ends with CR LF. While a bus cycle or an answer is in progress, no further characters are taken in. Baud generation, serial framing and flash programming are handled elsewhere.

Top module: `ascii_bus_bridge`

## Requirements
- R1: A write line runs exactly one bus cycle with `bus_we`=1. `bus_adr` is the address operand and `bus_dat_w` is the data operand, and in both the first digit received is the most significant nibble. The write line is "w" (0x77), "m" (0x6D), at least one space (0x20), 8 hex digits, at least one space, 8 hex digits, optional spaces, then CR (0x0D) or LF (0x0A).
- R2: A read line runs exactly one bus cycle with `bus_we`=0 and `bus_adr` equal to the address operand. The read line is "r" (0x72), "m", at least one space, 8 hex digits, optional spaces, then CR or LF.
- R3: When a read is acknowledged, the block sends the captured `bus_dat_r` as 8 uppercase ASCII hex digits, most significant nibble first, followed by 0x0D 0x0A.
- R4: When a write is acknowledged, the block sends "OK" (0x4F 0x4B) followed by 0x0D 0x0A.
- R5: Hex digits 0-9, A-F and a-f are all accepted, and runs of several spaces are accepted as separators. Before the first character of a command, spaces, CR and LF are ignored and produce no output.
- R6: The parser returns to idle and sends "ERR" (0x45 0x52 0x52) followed by 0x0D 0x0A, with no bus cycle, in any of these cases: an unknown first character, a second character other than "m", no space after the command word or between operands, a non-hex character inside an operand, fewer than 8 digits, or any character other than space, CR or LF after the final operand.
- R7: `bus_cyc` and `bus_stb` rise together in the clock after the line terminator is accepted. Address, data and `bus_we` stay stable while the cycle is open. The cycle stays open until `bus_ack` is sampled high and closes at that same edge.
- R8: If `bus_ack` is not seen during 255 consecutive clocks of an open cycle, the cycle ends after exactly 255 clocks and "ERR" CR LF is sent instead of the normal answer. An acknowledge in the 255th clock still counts as success.
- R9: `rx_ready` is low from the edge that accepts a line terminator or an offending character until the edge that hands over the last answer byte. It is high at every other time.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R11: After reset, `rx_ready` is high and `tx_valid`, `bus_cyc` and `bus_stb` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character present |
| rx_ready | output | 1 | Block can take a character |
| tx_data | output | 8 | Answer character |
| tx_valid | output | 1 | Answer character present |
| tx_ready | input | 1 | Transmitter takes the character |
| bus_adr | output | 32 | Bus address |
| bus_dat_w | output | 32 | Bus write data |
| bus_dat_r | input | 32 | Bus read data |
| bus_we | output | 1 | Bus write enable |
| bus_cyc | output | 1 | Bus cycle open |
| bus_stb | output | 1 | Bus strobe |
| bus_ack | input | 1 | Bus acknowledge |

## Verification
The bus cycle opens one clock after the edge that accepts the terminator, and it closes at the edge that samples `bus_ack`. A responder that acknowledges on its N-th open clock therefore yields a cycle exactly N clocks long, and a silent responder yields 255 clocks. The first answer byte appears in the clock after the closing edge, or after the edge that took an offending character. The bench drives its inputs and samples every output on the falling edge. It opens its expected-bus record on the first open clock, compares each answer byte only in a clock where valid and ready are both high, and compares cycle lengths when `bus_cyc` falls.

// File: rtl/ascii_bus_bridge.sv
`timescale 1ns/1ps
module ascii_bus_bridge #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ACK_WAIT = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [AW-1:0] bus_adr,
  output logic [DW-1:0] bus_dat_w,
  input  logic [DW-1:0] bus_dat_r,
  output logic          bus_we,
  output logic          bus_cyc,
  output logic          bus_stb,
  input  logic          bus_ack
);
  localparam int ADIG = AW / 4;
  localparam int DDIG = DW / 4;
  localparam int CW   = $clog2((ADIG > DDIG ? ADIG : DDIG) + 1);
  localparam int TW   = $clog2(ACK_WAIT + 1);
  localparam int IW   = $clog2(DDIG + 3);
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_SP = 8'h20;

  typedef enum logic [3:0] {
    IDLE, VERB, GAP_A, PAD_A, ADDR, GAP_D, PAD_D, DATA, TAIL, BUS, SEND
  } state_t;
  typedef enum logic [1:0] {RSP_OK, RSP_ERR, RSP_HEX} rsp_t;

  state_t        st;
  rsp_t          rsp;
  logic          wr;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] dat_q;
  logic [CW-1:0] dcnt;
  logic [TW-1:0] wcnt;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;

  logic       take, is_hex, is_sp, is_eol;
  logic [3:0] nib;

  assign rx_ready  = (st != BUS) && (st != SEND);
  assign take      = rx_valid && rx_ready;
  assign is_sp     = rx_data == CH_SP;
  assign is_eol    = (rx_data == CH_CR) || (rx_data == CH_LF);
  assign bus_cyc   = st == BUS;
  assign bus_stb   = bus_cyc;
  assign bus_we    = bus_cyc && wr;
  assign bus_adr   = adr_q;
  assign bus_dat_w = dat_q;
  assign tx_valid  = st == SEND;

  always_comb begin
    is_hex = 1'b1;
    nib    = 4'h0;
    if (rx_data >= 8'h30 && rx_data <= 8'h39)
      nib = rx_data[3:0];
    else if ((rx_data >= 8'h41 && rx_data <= 8'h46) || (rx_data >= 8'h61 && rx_data <= 8'h66))
      nib = rx_data[3:0] + 4'd9;
    else
      is_hex = 1'b0;
  end

  always_comb begin
    case (rsp)
      RSP_OK:  last_idx = IW'(3);
      RSP_ERR: last_idx = IW'(4);
      default: last_idx = IW'(DDIG + 1);
    endcase
  end

  always_comb begin
    logic [3:0] hn;
    hn      = 4'h0;
    tx_data = CH_LF;
    case (rsp)
      RSP_OK: begin
        if (idx == IW'(0))      tx_data = 8'h4F;
        else if (idx == IW'(1)) tx_data = 8'h4B;
        else if (idx == IW'(2)) tx_data = CH_CR;
      end
      RSP_ERR: begin
        if (idx == IW'(0))                       tx_data = 8'h45;
        else if (idx == IW'(1) || idx == IW'(2)) tx_data = 8'h52;
        else if (idx == IW'(3))                  tx_data = CH_CR;
      end
      default: begin
        if (int'(idx) < DDIG) begin
          hn      = dat_q[DW - 4 - 4 * int'(idx) +: 4];
          tx_data = (hn < 4'd10) ? (8'h30 + {4'h0, hn}) : (8'h37 + {4'h0, hn});
        end else if (int'(idx) == DDIG) begin
          tx_data = CH_CR;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      rsp   <= RSP_OK;
      wr    <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
      dcnt  <= '0;
      wcnt  <= '0;
      idx   <= '0;
    end else begin
      case (st)
        IDLE: if (take && !is_sp && !is_eol) begin
          if (rx_data == 8'h77) begin
            wr <= 1'b1;
            st <= VERB;
          end else if (rx_data == 8'h72) begin
            wr <= 1'b0;
            st <= VERB;
          end else begin
            rsp <= RSP_ERR; idx <= '0; st <= SEND;
          end
        end
        VERB: if (take) begin
          if (rx_data == 8'h6D) st <= GAP_A;
          else begin rsp <= RSP_ERR; idx <= '0; st <= SEND; end
        end
        GAP_A: if (take) begin
          if (is_sp) st <= PAD_A;
          else begin rsp <= RSP_ERR; idx <= '0; st <= SEND; end
        end
        PAD_A: if (take && !is_sp) begin
          if (is_hex) begin
            adr_q <= {adr_q[AW-5:0], nib};
            dcnt  <= CW'(1);
            st    <= ADDR;
          end else begin
            rsp <= RSP_ERR; idx <= '0; st <= SEND;
          end
        end
        ADDR: if (take) begin
          if (is_hex) begin
            adr_q <= {adr_q[AW-5:0], nib};
            if (dcnt == CW'(ADIG - 1)) begin
              dcnt <= '0;
              st   <= wr ? GAP_D : TAIL;
            end else begin
              dcnt <= dcnt + CW'(1);
            end
          end else begin
            rsp <= RSP_ERR; idx <= '0; st <= SEND;
          end
        end
        GAP_D: if (take) begin
          if (is_sp) st <= PAD_D;
          else begin rsp <= RSP_ERR; idx <= '0; st <= SEND; end
        end
        PAD_D: if (take && !is_sp) begin
          if (is_hex) begin
            dat_q <= {dat_q[DW-5:0], nib};
            dcnt  <= CW'(1);
            st    <= DATA;
          end else begin
            rsp <= RSP_ERR; idx <= '0; st <= SEND;
          end
        end
        DATA: if (take) begin
          if (is_hex) begin
            dat_q <= {dat_q[DW-5:0], nib};
            if (dcnt == CW'(DDIG - 1)) begin
              dcnt <= '0;
              st   <= TAIL;
            end else begin
              dcnt <= dcnt + CW'(1);
            end
          end else begin
            rsp <= RSP_ERR; idx <= '0; st <= SEND;
          end
        end
        TAIL: if (take && !is_sp) begin
          if (is_eol) begin
            wcnt <= '0;
            st   <= BUS;
          end else begin
            rsp <= RSP_ERR; idx <= '0; st <= SEND;
          end
        end
        BUS: begin
          if (bus_ack) begin
            if (!wr) dat_q <= bus_dat_r;
            rsp <= wr ? RSP_OK : RSP_HEX;
            idx <= '0;
            st  <= SEND;
          end else if (wcnt == TW'(ACK_WAIT - 1)) begin
            rsp <= RSP_ERR;
            idx <= '0;
            st  <= SEND;
          end else begin
            wcnt <= wcnt + TW'(1);
          end
        end
        SEND: if (tx_ready) begin
          if (idx == last_idx) st <= IDLE;
          else idx <= idx + IW'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module ascii_bus_bridge_chk #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ACK_WAIT = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [AW-1:0] bus_adr,
  input logic [DW-1:0] bus_dat_w,
  input logic          bus_we,
  input logic          bus_cyc,
  input logic          bus_ack
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= '0;
    else if (bus_cyc) run <= run + 16'd1;
    else              run <= '0;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ack && (run != 16'(ACK_WAIT - 1)) |=> bus_cyc);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && bus_ack |=> !bus_cyc);

  assert_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && $past(bus_cyc) |-> $stable(bus_adr) && $stable(bus_dat_w) && $stable(bus_we));

  assert_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> run < 16'(ACK_WAIT));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc || tx_valid |-> !rx_ready);

  assert_txhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
endmodule

bind ascii_bus_bridge ascii_bus_bridge_chk #(.AW(AW), .DW(DW), .ACK_WAIT(ACK_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .bus_adr(bus_adr), .bus_dat_w(bus_dat_w), .bus_we(bus_we),
  .bus_cyc(bus_cyc), .bus_ack(bus_ack)
);

// File: tb/sim_ascii_bus_bridge.sv
`timescale 1ns/1ps
module sim_ascii_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [31:0] bus_adr, bus_dat_w;
  logic [31:0] bus_dat_r = 32'h0;
  logic        bus_we, bus_cyc, bus_stb;
  logic        bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  ascii_bus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .bus_adr(bus_adr),
    .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r), .bus_we(bus_we), .bus_cyc(bus_cyc),
    .bus_stb(bus_stb), .bus_ack(bus_ack)
  );

  byte unsigned exp_tx[$];
  logic [31:0]  q_adr[$], q_dat[$], q_rd[$];
  bit           q_we[$];
  int    n_chk = 0, n_bad = 0, tick = 0;
  int    lat = 0, exp_len = 1, cyc_len = 0;
  bit    no_ack = 0, bp = 0, cyc_prev = 0;
  bit    tx_prev_v = 0, tx_prev_r = 0;
  logic [7:0]  tx_prev_d = 8'h00;
  logic [31:0] rd_val = 32'h0;
  string tx_req = "R4", bus_req = "R1";

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick++;
    if (tick > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", tick, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
    if (rst_n) begin
      tx_ready = bp ? (tick % 3 != 0) : 1'b1;
      if (bus_cyc && !cyc_prev) begin
        chk(bus_stb, "R7", "strobe with cycle", {31'b0, bus_stb}, 1);
        if (q_adr.size() == 0) begin
          chk(0, "R6", "unexpected bus cycle", bus_adr, 0);
        end else begin
          chk(bus_adr == q_adr[0], bus_req, "bus address", bus_adr, q_adr[0]);
          chk(bus_we == q_we[0], bus_req, "write enable", {31'b0, bus_we}, {31'b0, q_we[0]});
          if (q_we[0]) chk(bus_dat_w == q_dat[0], bus_req, "write data", bus_dat_w, q_dat[0]);
          rd_val = q_rd[0];
          void'(q_adr.pop_front()); void'(q_dat.pop_front());
          void'(q_rd.pop_front());  void'(q_we.pop_front());
        end
      end
      if (bus_cyc || tx_valid)
        chk(!rx_ready, "R9", "ready low while busy", {31'b0, rx_ready}, 0);
      if (!bus_cyc && cyc_prev)
        chk(cyc_len == exp_len, no_ack ? "R8" : "R7", "cycle length", cyc_len, exp_len);
      if (tx_prev_v && !tx_prev_r)
        chk(tx_valid && tx_data == tx_prev_d, "R10", "held byte", {23'b0, tx_valid, tx_data},
            {24'h000001, tx_prev_d});
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk(0, tx_req, "unexpected byte", {24'h0, tx_data}, 0);
        else begin
          chk(tx_data == exp_tx[0], tx_req, "answer byte", {24'h0, tx_data}, {24'h0, exp_tx[0]});
          void'(exp_tx.pop_front());
        end
      end
      cyc_len  = bus_cyc ? (cyc_prev ? cyc_len + 1 : 1) : 0;
      cyc_prev = bus_cyc;
      bus_ack  = bus_cyc && !no_ack && (cyc_len == lat + 1);
      bus_dat_r = rd_val;
      tx_prev_v = tx_valid;
      tx_prev_r = tx_ready;
      tx_prev_d = tx_data;
    end
  end

  task automatic send(string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = s[i];
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic push_str(string s);
    for (int i = 0; i < s.len(); i++) exp_tx.push_back(s[i]);
  endtask

  task automatic exp_bus(bit we, logic [31:0] a, logic [31:0] d, logic [31:0] r);
    q_we.push_back(we); q_adr.push_back(a); q_dat.push_back(d); q_rd.push_back(r);
  endtask

  task automatic settle(string req);
    int guard = 0;
    while ((exp_tx.size() != 0 || tx_valid || bus_cyc) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(exp_tx.size() == 0, req, "answer bytes missing", exp_tx.size(), 0);
    chk(q_adr.size() == 0, req, "bus cycle missing", q_adr.size(), 0);
    chk(rx_ready, "R9", "ready after answer", {31'b0, rx_ready}, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready, "R11", "reset rx_ready", {31'b0, rx_ready}, 1);
    chk(!tx_valid, "R11", "reset tx_valid", {31'b0, tx_valid}, 0);
    chk(!bus_cyc && !bus_stb, "R11", "reset cycle", {30'b0, bus_cyc, bus_stb}, 0);

    // R1 R4: plain write, immediate acknowledge
    lat = 0; exp_len = 1; tx_req = "R4"; bus_req = "R1";
    exp_bus(1, 32'h10000004, 32'hDEADBEEF, 0);
    push_str("OK\r\n");
    send("wm 10000004 DEADBEEF\r");
    settle("R1");

    // R2 R3: read with latency and LF terminator
    lat = 3; exp_len = 4; tx_req = "R3"; bus_req = "R2";
    exp_bus(0, 32'h10000004, 0, 32'h0BADF00D);
    push_str("0BADF00D\r\n");
    send("rm 10000004\n");
    settle("R3");

    // R5 R10: lower case, multiple spaces, trailing spaces, backpressure
    lat = 1; exp_len = 2; bp = 1; tx_req = "R5"; bus_req = "R5";
    exp_bus(1, 32'hABCDEF01, 32'h12345678, 0);
    push_str("OK\r\n");
    send(" \r\nwm   abcdef01  12345678  \n");
    settle("R5");

    // R3 R10: read with mixed case digits, answer under backpressure
    lat = 2; exp_len = 3; tx_req = "R3"; bus_req = "R5";
    exp_bus(0, 32'hABCD0123, 0, 32'hA5C3E1F0);
    push_str("A5C3E1F0\r\n");
    send("rm aBcD0123\r");
    settle("R10");
    bp = 0;

    // R8: acknowledge in the last allowed clock still succeeds
    lat = 254; exp_len = 255; tx_req = "R8"; bus_req = "R2";
    exp_bus(0, 32'h00000000, 0, 32'hFFFFFFFF);
    push_str("FFFFFFFF\r\n");
    send("rm 00000000\r");
    settle("R8");

    // R8: silent responder on a read and on a write
    no_ack = 1; exp_len = 255; tx_req = "R8"; bus_req = "R2";
    exp_bus(0, 32'h20000000, 0, 0);
    push_str("ERR\r\n");
    send("rm 20000000\r");
    settle("R8");
    bus_req = "R1";
    exp_bus(1, 32'h30000010, 32'h00000001, 0);
    push_str("ERR\r\n");
    send("wm 30000010 00000001\n");
    settle("R8");
    no_ack = 0;

    // R6: malformed lines, each gives one ERR and no bus cycle
    lat = 0; exp_len = 1; tx_req = "R6";
    push_str("ERR\r\n"); send("x");             settle("R6");
    push_str("ERR\r\n"); send("wq");            settle("R6");
    push_str("ERR\r\n"); send("wm1\r");         settle("R6");
    push_str("ERR\r\n"); send("rm 1234G\r");    settle("R6");
    push_str("ERR\r\n"); send("rm 1234\r");     settle("R6");
    push_str("ERR\r\n"); send("rm 123456789\r"); settle("R6");
    push_str("ERR\r\n"); send("rm 12345678 x\n"); settle("R6");
    push_str("ERR\r\n"); send("wm 12345678 9abc\r"); settle("R6");
    push_str("ERR\r\n"); send("wm 12345678\r"); settle("R6");

    // R1: parser recovered after errors
    tx_req = "R4"; bus_req = "R1";
    exp_bus(1, 32'hFFFFFFFF, 32'h00000000, 0);
    push_str("OK\r\n");
    send("wm FFFFFFFF 00000000\r");
    settle("R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule